// File: doc/BRIEF.md
# Fractional-Rate Power-Management Timer

This block keeps a free-running power-management count that advances at a nominal 3.579545 MHz while being clocked from an unrelated system clock. Each system clock adds a fixed-point step of 32 integer and 32 fraction bits to a phase accumulator. The integer part, plus the carry out of the fraction, is added to the count, so no fractional time is lost from one cycle to the next. The step constant is computed at elaboration from the system clock frequency parameter.

A host reads the count through a small request/response port. Only full four-byte reads return data. A four-byte write is acknowledged and discarded. Any other access size is rejected with an error response. Each time the count's most significant bit changes, in either direction, the block emits a one-cycle event pulse. A neighbouring status block uses that pulse to set its timer status flag.

The host port is a four-state machine. In `P_IDLE` a request is accepted. A four-byte read moves to `P_READ`, a four-byte write moves to `P_WACK`, and any other size moves to `P_REJ`. Each of the three response states lasts one cycle, drives the response, and returns to `P_IDLE`. A request presented while not in `P_IDLE` is ignored.

Top module: `pmt_timer`

## Requirements
- R1: The step constant is floor(3579545 * 2^32 / SYS_CLK_HZ). After k clock edges with reset released, the count equals floor(k * step / 2^32) modulo 2^CNT_W, so no fraction is ever dropped.
- R2: Reset clears the count and the fraction to zero, and holds `rsp_valid`, `rsp_err` and `tmr_evt` low.
- R3: The count wraps modulo 2^CNT_W and keeps counting after the wrap.
- R4: `tmr_evt` is high for exactly the one cycle after an edge at which count bit CNT_W-1 changed value, both on 0 to 1 and on 1 to 0.
- R5: A request with `req_write`=0 and `req_size`=4 accepted at an edge gives `rsp_valid`=1 and `rsp_err`=0 in the following cycle. `rsp_rdata` then holds the zero-extended count as updated at that same edge.
- R6: A request with `req_write`=1 and `req_size`=4 gets `rsp_valid`=1, `rsp_err`=0 and `rsp_rdata`=0, and has no effect on the count, whatever `req_wdata` holds.
- R7: A request whose `req_size` is not 4 gets `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0, and has no effect on the count.
- R8: `rsp_valid` lasts one cycle per accepted request. A request held during a response cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host access request, sampled in `P_IDLE` |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data (always discarded) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response marks a rejected access size |
| rsp_rdata | output | 32 | Read data, zero-extended count |
| tmr_evt | output | 1 | Pulse on each change of the count's top bit |

## Verification
A wrong fraction or a dropped carry shows up as a read value that falls behind floor(k * step / 2^32). The error appears within a few reads and grows steadily. A wrong top-bit tracker gives an event pulse that is missing, doubled or one cycle late at a top-bit change, and that change comes about every 2^(CNT_W-1) counts. A port state machine in the wrong state shows on the very next response, as a wrong error flag, stray data or a strobe longer than one cycle. The bench uses a 12-bit count and a 2 MHz nominal system clock. That gives a step with a non-zero integer part, so several wraps and both directions of top-bit change happen in a short run. Every cycle is compared against the arithmetic model.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam longint unsigned NOM_RATE_HZ = 64'd3579545;
    localparam logic [2:0]      FULL_ACCESS = 3'd4;

    typedef enum logic [1:0] {
        P_IDLE = 2'd0,
        P_READ = 2'd1,
        P_WACK = 2'd2,
        P_REJ  = 2'd3
    } port_state_e;

    // 32.32 fixed-point count increment per system clock
    function automatic logic [63:0] calc_scale(input longint unsigned sys_hz);
        return (NOM_RATE_HZ << 32) / sys_hz;
    endfunction

endpackage

// File: rtl/pmt_accum.sv
module pmt_accum #(
    parameter int unsigned CNT_W = 32,
    parameter logic [63:0] SCALE = 64'h0000_0000_8000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [31:0]      FRAC  = SCALE[31:0];
    localparam logic [CNT_W-1:0] WHOLE = CNT_W'(SCALE[63:32]);

    logic [31:0] frac_q;
    logic [32:0] frac_sum;

    always_comb begin
        frac_sum = {1'b0, frac_q} + {1'b0, FRAC};
        cnt_nxt  = cnt_q + WHOLE + CNT_W'(frac_sum[32]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q <= '0;
            cnt_q  <= '0;
        end else begin
            frac_q <= frac_sum[31:0];
            cnt_q  <= cnt_nxt;
        end
    end

    // R1: each step is the integer part, or the integer part plus one carry
    a_r1_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((CNT_W'(cnt_q - $past(cnt_q)) == WHOLE) ||
                          (CNT_W'(cnt_q - $past(cnt_q)) == CNT_W'(WHOLE + 1'b1))));

    // R2: the first cycle out of reset starts from zero
    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cnt_q == '0));

endmodule

// File: rtl/pmt_edge.sv
module pmt_edge #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             tmr_evt
);
    localparam int unsigned TOP = CNT_W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_evt <= 1'b0;
        else        tmr_evt <= cnt_nxt[TOP] ^ cnt_q[TOP];
    end

    // R4: pulse exactly when the stored top bit has changed
    a_r4_evt_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tmr_evt == (cnt_q[TOP] != $past(cnt_q[TOP]))));

endmodule

// File: rtl/pmt_port.sv
module pmt_port #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic [2:0]       req_size,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [31:0]      rsp_rdata
);
    import pmt_pkg::*;

    port_state_e state_q, state_d;
    logic [31:0] cap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE: begin
                if (req) begin
                    if (req_size != FULL_ACCESS) state_d = P_REJ;
                    else if (req_write)          state_d = P_WACK;
                    else                         state_d = P_READ;
                end
            end
            P_READ:  state_d = P_IDLE;
            P_WACK:  state_d = P_IDLE;
            P_REJ:   state_d = P_IDLE;
            default: state_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    // capture the count as updated at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (state_q == P_IDLE && state_d == P_READ)
            cap_q <= 32'(cnt_nxt);
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            P_IDLE: ;
            P_READ: begin
                rsp_valid = 1'b1;
                rsp_rdata = cap_q;
            end
            P_WACK:  rsp_valid = 1'b1;
            P_REJ: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: response strobe is a single cycle
    a_r8_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7: a rejected access carries no data
    a_r7_rej_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'd0));

    // R7: a bad size accepted in idle always leads to an error response
    a_r7_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == P_IDLE && req && req_size != FULL_ACCESS) |=> (rsp_valid && rsp_err));

    // R6: a full-size write is acknowledged without error or data
    a_r6_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == P_IDLE && req && req_write && req_size == FULL_ACCESS)
            |=> (rsp_valid && !rsp_err && rsp_rdata == 32'd0));

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer #(
    parameter int unsigned SYS_CLK_HZ = 50_000_000,
    parameter int unsigned CNT_W      = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_write,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        tmr_evt
);
    localparam logic [63:0] SCALE = pmt_pkg::calc_scale(64'(SYS_CLK_HZ));

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wdata_unused;

    assign wdata_unused = ^req_wdata;

    pmt_accum #(.CNT_W(CNT_W), .SCALE(SCALE)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    pmt_edge #(.CNT_W(CNT_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .tmr_evt (tmr_evt)
    );

    pmt_port #(.CNT_W(CNT_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .req_size  (req_size),
        .cnt_nxt   (cnt_nxt),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: tb/sim_pmt_timer.sv
`timescale 1ns/1ps
module sim_pmt_timer;
    localparam int unsigned W  = 12;
    localparam int unsigned HZ = 2_000_000;
    localparam longint unsigned STEP = (64'd3579545 << 32) / 64'(HZ);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = 3'd0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, tmr_evt;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    int unsigned n = 0;
    int rises = 0;
    int falls = 0;
    int wraps = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pmt_timer #(.SYS_CLK_HZ(HZ), .CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .tmr_evt(tmr_evt)
    );

    function automatic longint unsigned model(input longint unsigned k);
        return ((k * STEP) >> 32) & ((64'd1 << W) - 1);
    endfunction

    task automatic check(input bit ok, input string req_tag,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at n=%0d", req_tag, act, exp, n);
        end
    endtask

    always @(posedge clk) if (rst_n) n <= n + 1;

    // R4: per-cycle event model, R3 wrap tracking
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_evt;
            exp_evt = (n >= 1) &&
                      (model(n) >> (W-1)) != (model(n-1) >> (W-1));
            check(tmr_evt == exp_evt, "R4", tmr_evt, exp_evt);
            if (exp_evt && (model(n) >> (W-1)) == 1) rises++;
            if (exp_evt && (model(n) >> (W-1)) == 0) falls++;
            if (n >= 1 && model(n) < model(n-1)) wraps++;
        end
    end

    task automatic access(input bit wr, input logic [2:0] sz, input logic [31:0] wd,
                          input string tag);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        check(rsp_valid == 1'b1, tag, rsp_valid, 1);
        if (sz != 3'd4) begin
            check(rsp_err == 1'b1 && rsp_rdata == 0, "R7", rsp_rdata, 0);
        end else if (wr) begin
            check(rsp_err == 1'b0 && rsp_rdata == 0, "R6", rsp_rdata, 0);
        end else begin
            check(rsp_err == 1'b0, "R5", rsp_err, 0);
            check(rsp_rdata == model(n), tag, rsp_rdata, model(n));
        end
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8", rsp_valid, 0);
    endtask

    initial begin
        #(200000 * 20);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: outputs quiet during reset
        check(rsp_valid == 0 && rsp_err == 0 && tmr_evt == 0, "R2", rsp_valid, 0);
        rst_n = 1'b1;
        // R2: first read shows count started from zero
        access(1'b0, 3'd4, 32'd0, "R2");

        // R8: request held through the response cycle is ignored
        @(negedge clk);
        req = 1'b1; req_write = 1'b0; req_size = 3'd4;
        @(negedge clk);
        check(rsp_valid == 1'b1 && rsp_rdata == model(n), "R8", rsp_rdata, model(n));
        @(negedge clk);
        req = 1'b0;
        check(rsp_valid == 1'b0, "R8", rsp_valid, 0);

        // sweep: reads at varying gaps, writes, every bad size
        for (int i = 0; n < 11000; i++) begin
            repeat (i % 13) @(negedge clk);
            access(1'b0, 3'd4, 32'd0, "R1");
            if (i % 5 == 0) begin
                access(1'b1, 3'd4, 32'hFFFF_FFFF - 32'(i), "R6");
                access(1'b0, 3'd4, 32'd0, "R6");
            end
            if (i % 7 == 0) begin
                logic [2:0] bad;
                bad = 3'(i / 7) % 3'd7;
                if (bad >= 3'd4) bad = bad + 3'd1;
                access(i % 2 == 0, bad, 32'h1234_5678, "R7");
                access(1'b0, 3'd4, 32'd0, "R7");
            end
        end

        // R3: wrap observed and reads stayed on the model across it
        check(wraps >= 2, "R3", wraps, 2);
        access(1'b0, 3'd4, 32'd0, "R3");
        // R4: both directions of top-bit change occurred
        check(rises >= 2, "R4", rises, 2);
        check(falls >= 2, "R4", falls, 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule